// File: doc/BRIEF.md
# Speculative Cache-Line Version State Engine

This block keeps the coherence state and the version range of every way in one cache set when iterations of a loop run speculatively. Each way holds one of the five ordinary states (Modified, Owned, Exclusive, Shared, Invalid) or one of four speculative counterparts. Each way also holds a pair of iteration stamps. The first, `m`, is the iteration that created the version. The second, `h`, is the latest iteration that touched it. A local speculative access names a way, an iteration number and a read or write. A write splits the line into two versions. The written way becomes the newest speculative-modified copy. A free way in the same set takes the superseded version as a speculative-owned copy, and the block reports which way that is so that the data path can move the bytes.

A snoop port reports what a remote reader would receive: a speculative-shared copy that carries the supplier's stamps. Three set-wide commands rewrite all ways in one cycle. Commit makes the surviving versions ordinary. Abort restores the states that existed before speculation. Stamp reset clears every stamp when the iteration counter has to wrap. A fill port installs a state and its stamps when a line arrives, and a probe port reads any way back. Data storage and memory traffic belong to the surrounding cache.

Top module: `spec_line_engine`

## Requirements
- R1: After synchronous reset every way is Invalid (code 0) with both stamps zero, and no response, snoop or probe output is valid.
- R2: A write by iteration z to a way in M (4), E (2), speculative-modified SM (12) or speculative-exclusive SE (10) with stamps (x,y) makes that way SM with (z,z). The lowest-numbered Invalid way becomes speculative-owned SO (11) with (x,z), and `rsp_copy_way` reports that way.
- R3: A write to an SE way or to an SM way splits the line in the same way as in R2, so a line written twice leaves an SO copy of its previous version.
- R4: A write that finds no Invalid way changes no state. Its response has `rsp_stall` and `evict_req` set and no copy.
- R5: A write to a way in O (3), S (1), SO, speculative-shared SS (9) or I is rejected with `rsp_reject` and changes nothing. A read of an Invalid way is rejected the same way.
- R6: A read by iteration v of a valid way sets `h` to the larger of `h` and v. It also moves an ordinary state to its speculative counterpart (M to SM, E to SE, O to SO, S to SS) and leaves `m` unchanged.
- R7: A snoop of an SM, SO or SE way reports a hit with state SS and the way's own (m,h). A snoop of any other state, SS included, reports no hit.
- R8: Commit maps SM to M, SE to E, and SO and SS to I. It leaves ordinary states and all stamps untouched.
- R9: Abort maps SE to E and SS to I. SM and SO go to M when `m` is zero and to I otherwise. Ordinary states are untouched.
- R10: Stamp reset sets both stamps of every way to zero and leaves all states as they were.
- R11: Priority within one cycle is stamp reset, then abort, then commit, then fill, then the request. A request that meets any of the four is not applied and answers with `rsp_stall` set and `evict_req` clear.
- R12: A fill writes the given 4-bit state code and stamps into the named way, and the probe port returns the state and stamps that a way holds one cycle after the probe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Local speculative access present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_way | input | WAY_W | Way accessed |
| req_vid | input | VID_W | Iteration number of the requester |
| fill_valid | input | 1 | Install a state into a way |
| fill_way | input | WAY_W | Way to install |
| fill_state | input | 4 | State code to install |
| fill_m | input | VID_W | Creation stamp to install |
| fill_h | input | VID_W | Access stamp to install |
| cmd_commit | input | 1 | Commit all speculative versions |
| cmd_abort | input | 1 | Abort all speculative versions |
| cmd_vid_rst | input | 1 | Clear all stamps |
| snp_valid | input | 1 | Remote read lookup present |
| snp_way | input | WAY_W | Way matched by the remote address |
| prb_req | input | 1 | Probe request |
| prb_way | input | WAY_W | Way to probe |
| rsp_valid | output | 1 | Response to last cycle's request |
| rsp_stall | output | 1 | Request not applied, retry |
| rsp_reject | output | 1 | Request not permitted in the way's state |
| rsp_copy_vld | output | 1 | Write split the line |
| rsp_copy_way | output | WAY_W | Way that received the superseded version |
| evict_req | output | 1 | A way must be freed before the write can proceed |
| snp_rsp_vld | output | 1 | Snoop answer valid |
| snp_hit | output | 1 | This set supplies the line |
| snp_state | output | 4 | State the remote copy takes |
| snp_m | output | VID_W | Creation stamp for the remote copy |
| snp_h | output | VID_W | Access stamp for the remote copy |
| prb_vld | output | 1 | Probe answer valid |
| prb_state | output | 4 | Probed state code |
| prb_m | output | VID_W | Probed creation stamp |
| prb_h | output | VID_W | Probed access stamp |

## Verification
The bench writes lines that start from M, from SE and from SM. It checks that the SO copy always lands in the lowest Invalid way with the old creation stamp, and it checks a write with the set full, which separates the stall and evict path from the split. Reads with a smaller iteration number after a larger one show that the access stamp takes the maximum and is not simply overwritten. Commit and abort are each applied to a set holding every speculative state, with both zero and nonzero creation stamps, so that the two mappings can be told apart. Commands are raised in the same cycle as a request, a fill or each other to confirm the priority order.

// File: rtl/spec_line_pkg.sv
package spec_line_pkg;

  typedef enum logic [3:0] {
    LS_I  = 4'd0,
    LS_S  = 4'd1,
    LS_E  = 4'd2,
    LS_O  = 4'd3,
    LS_M  = 4'd4,
    LS_SS = 4'd9,
    LS_SE = 4'd10,
    LS_SO = 4'd11,
    LS_SM = 4'd12
  } lstate_e;

  // Speculative counterpart taken on a speculative read.
  function automatic lstate_e to_spec(lstate_e s);
    case (s)
      LS_M:    return LS_SM;
      LS_E:    return LS_SE;
      LS_O:    return LS_SO;
      LS_S:    return LS_SS;
      default: return s;
    endcase
  endfunction

  function automatic lstate_e commit_map(lstate_e s);
    case (s)
      LS_SM:        return LS_M;
      LS_SE:        return LS_E;
      LS_SO, LS_SS: return LS_I;
      default:      return s;
    endcase
  endfunction

  // m_zero: the version predates speculation.
  function automatic lstate_e abort_map(lstate_e s, logic m_zero);
    case (s)
      LS_SE:        return LS_E;
      LS_SS:        return LS_I;
      LS_SM, LS_SO: return m_zero ? LS_M : LS_I;
      default:      return s;
    endcase
  endfunction

  function automatic logic can_write(lstate_e s);
    return (s == LS_M) || (s == LS_E) || (s == LS_SM) || (s == LS_SE);
  endfunction

  function automatic logic supplies(lstate_e s);
    return (s == LS_SM) || (s == LS_SO) || (s == LS_SE);
  endfunction

endpackage

// File: rtl/spec_free_pick.sv
module spec_free_pick #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  free_vec,
  output logic             any_free,
  output logic [WAY_W-1:0] free_idx
);
  // Lowest-index free way wins: scan downward so the last hit is the lowest.
  always_comb begin
    any_free = |free_vec;
    free_idx = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (free_vec[i]) free_idx = WAY_W'(i);
    end
  end
endmodule

// File: rtl/spec_line_way.sv
module spec_line_way
  import spec_line_pkg::*;
#(
  parameter int VID_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vrst,
  input  logic             abort,
  input  logic             commit,
  input  logic             fill_en,
  input  lstate_e          fill_st,
  input  logic [VID_W-1:0] fill_m,
  input  logic [VID_W-1:0] fill_h,
  input  logic             wr_en,
  input  logic             cp_en,
  input  logic [VID_W-1:0] cp_m,
  input  logic             rd_en,
  input  logic [VID_W-1:0] vid,
  output lstate_e          st_o,
  output logic [VID_W-1:0] m_o,
  output logic [VID_W-1:0] h_o
);
  lstate_e          st_q;
  logic [VID_W-1:0] m_q, h_q;
  logic [VID_W-1:0] h_max;

  assign h_max = (vid > h_q) ? vid : h_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= LS_I;
      m_q  <= '0;
      h_q  <= '0;
    end else if (vrst) begin
      m_q <= '0;
      h_q <= '0;
    end else if (abort) begin
      st_q <= abort_map(st_q, m_q == '0);
    end else if (commit) begin
      st_q <= commit_map(st_q);
    end else if (fill_en) begin
      st_q <= fill_st;
      m_q  <= fill_m;
      h_q  <= fill_h;
    end else if (wr_en) begin
      st_q <= LS_SM;
      m_q  <= vid;
      h_q  <= vid;
    end else if (cp_en) begin
      st_q <= LS_SO;
      m_q  <= cp_m;
      h_q  <= vid;
    end else if (rd_en) begin
      st_q <= to_spec(st_q);
      h_q  <= h_max;
    end
  end

  assign st_o = st_q;
  assign m_o  = m_q;
  assign h_o  = h_q;
endmodule

// File: rtl/spec_line_engine.sv
module spec_line_engine
  import spec_line_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int VID_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [WAY_W-1:0] req_way,
  input  logic [VID_W-1:0] req_vid,
  input  logic             fill_valid,
  input  logic [WAY_W-1:0] fill_way,
  input  logic [3:0]       fill_state,
  input  logic [VID_W-1:0] fill_m,
  input  logic [VID_W-1:0] fill_h,
  input  logic             cmd_commit,
  input  logic             cmd_abort,
  input  logic             cmd_vid_rst,
  input  logic             snp_valid,
  input  logic [WAY_W-1:0] snp_way,
  input  logic             prb_req,
  input  logic [WAY_W-1:0] prb_way,
  output logic             rsp_valid,
  output logic             rsp_stall,
  output logic             rsp_reject,
  output logic             rsp_copy_vld,
  output logic [WAY_W-1:0] rsp_copy_way,
  output logic             evict_req,
  output logic             snp_rsp_vld,
  output logic             snp_hit,
  output logic [3:0]       snp_state,
  output logic [VID_W-1:0] snp_m,
  output logic [VID_W-1:0] snp_h,
  output logic             prb_vld,
  output logic [3:0]       prb_state,
  output logic [VID_W-1:0] prb_m,
  output logic [VID_W-1:0] prb_h
);
  localparam int ST_W = 4;

  lstate_e          st_w [WAYS];
  logic [VID_W-1:0] m_w  [WAYS];
  logic [VID_W-1:0] h_w  [WAYS];
  logic [WAYS-1:0]  free_vec;
  logic [WAYS*ST_W-1:0]  st_flat;
  logic [WAYS*VID_W-1:0] ts_flat;

  logic             any_free;
  logic [WAY_W-1:0] free_idx;
  logic             cmd_any, blocked;
  lstate_e          tgt_st;
  logic             wr_ok, do_wr, wr_nofree, rd_ok, rej;

  // Request qualification
  always_comb begin
    cmd_any   = cmd_vid_rst | cmd_abort | cmd_commit;
    blocked   = cmd_any | fill_valid;
    tgt_st    = st_w[req_way];
    wr_ok     = req_valid & ~blocked & req_write & can_write(tgt_st);
    do_wr     = wr_ok & any_free;
    wr_nofree = wr_ok & ~any_free;
    rd_ok     = req_valid & ~blocked & ~req_write & (tgt_st != LS_I);
    rej       = req_valid & ~blocked &
                ((req_write & ~can_write(tgt_st)) | (~req_write & (tgt_st == LS_I)));
  end

  spec_free_pick #(.WAYS(WAYS)) pick_i (
    .free_vec (free_vec),
    .any_free (any_free),
    .free_idx (free_idx)
  );

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    spec_line_way #(.VID_W(VID_W)) way_i (
      .clk     (clk),
      .rst     (rst),
      .vrst    (cmd_vid_rst),
      .abort   (cmd_abort),
      .commit  (cmd_commit),
      .fill_en (fill_valid && (fill_way == WAY_W'(g))),
      .fill_st (lstate_e'(fill_state)),
      .fill_m  (fill_m),
      .fill_h  (fill_h),
      .wr_en   (do_wr && (req_way == WAY_W'(g))),
      .cp_en   (do_wr && (free_idx == WAY_W'(g))),
      .cp_m    (m_w[req_way]),
      .rd_en   (rd_ok && (req_way == WAY_W'(g))),
      .vid     (req_vid),
      .st_o    (st_w[g]),
      .m_o     (m_w[g]),
      .h_o     (h_w[g])
    );
    assign free_vec[g]                 = (st_w[g] == LS_I);
    assign st_flat[g*ST_W +: ST_W]     = st_w[g];
    assign ts_flat[g*VID_W +: VID_W]   = m_w[g] | h_w[g];
  end

  // Registered request response
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_stall    <= 1'b0;
      rsp_reject   <= 1'b0;
      rsp_copy_vld <= 1'b0;
      rsp_copy_way <= '0;
      evict_req    <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_stall    <= req_valid & (blocked | wr_nofree);
      rsp_reject   <= rej;
      rsp_copy_vld <= do_wr;
      rsp_copy_way <= do_wr ? free_idx : '0;
      evict_req    <= wr_nofree;
    end
  end

  // Registered snoop answer; speculative-shared lines stay silent
  always_ff @(posedge clk) begin
    if (rst) begin
      snp_rsp_vld <= 1'b0;
      snp_hit     <= 1'b0;
      snp_state   <= LS_I;
      snp_m       <= '0;
      snp_h       <= '0;
    end else begin
      snp_rsp_vld <= snp_valid;
      snp_hit     <= snp_valid & supplies(st_w[snp_way]);
      snp_state   <= (snp_valid & supplies(st_w[snp_way])) ? LS_SS : LS_I;
      snp_m       <= m_w[snp_way];
      snp_h       <= h_w[snp_way];
    end
  end

  // Registered probe read
  always_ff @(posedge clk) begin
    if (rst) begin
      prb_vld   <= 1'b0;
      prb_state <= LS_I;
      prb_m     <= '0;
      prb_h     <= '0;
    end else begin
      prb_vld   <= prb_req;
      prb_state <= st_w[prb_way];
      prb_m     <= m_w[prb_way];
      prb_h     <= h_w[prb_way];
    end
  end
endmodule

// File: rtl/spec_line_engine_chk.sv
module spec_line_engine_chk #(
  parameter int WAYS  = 4,
  parameter int VID_W = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  req_valid,
  input logic                  fill_valid,
  input logic                  cmd_commit,
  input logic                  cmd_abort,
  input logic                  cmd_vid_rst,
  input logic                  rsp_valid,
  input logic                  rsp_stall,
  input logic                  rsp_reject,
  input logic                  rsp_copy_vld,
  input logic [WAY_W-1:0]      rsp_copy_way,
  input logic                  evict_req,
  input logic                  snp_rsp_vld,
  input logic                  snp_hit,
  input logic [3:0]            snp_state,
  input logic [WAYS*4-1:0]     st_flat,
  input logic [WAYS*VID_W-1:0] ts_flat
);
  logic any_spec;
  always_comb begin
    any_spec = 1'b0;
    for (int i = 0; i < WAYS; i++) any_spec = any_spec | st_flat[i*4+3];
  end

  // R4
  evict_stall_chk: assert property (@(posedge clk) disable iff (rst)
    evict_req |-> (rsp_valid && rsp_stall && !rsp_copy_vld));

  // R5
  reject_excl_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_reject |-> (rsp_valid && !rsp_stall && !rsp_copy_vld));

  // R7
  snoop_ss_chk: assert property (@(posedge clk) disable iff (rst)
    snp_hit |-> (snp_rsp_vld && snp_state == 4'd9));

  // R2
  copy_so_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_copy_vld |-> (st_flat[rsp_copy_way*4 +: 4] == 4'd11));

  // R10
  vid_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_vid_rst) |-> (ts_flat == '0));

  // R8
  commit_clean_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd_commit) && !$past(cmd_abort) && !$past(cmd_vid_rst)) |-> !any_spec);

  // R9
  abort_clean_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd_abort) && !$past(cmd_vid_rst)) |-> !any_spec);

  // R11
  cmd_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(cmd_commit || cmd_abort || cmd_vid_rst || fill_valid))
      |-> (rsp_stall && !evict_req && !rsp_copy_vld));
endmodule

bind spec_line_engine spec_line_engine_chk #(.WAYS(WAYS), .VID_W(VID_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .fill_valid   (fill_valid),
  .cmd_commit   (cmd_commit),
  .cmd_abort    (cmd_abort),
  .cmd_vid_rst  (cmd_vid_rst),
  .rsp_valid    (rsp_valid),
  .rsp_stall    (rsp_stall),
  .rsp_reject   (rsp_reject),
  .rsp_copy_vld (rsp_copy_vld),
  .rsp_copy_way (rsp_copy_way),
  .evict_req    (evict_req),
  .snp_rsp_vld  (snp_rsp_vld),
  .snp_hit      (snp_hit),
  .snp_state    (snp_state),
  .st_flat      (st_flat),
  .ts_flat      (ts_flat)
);

// File: tb/spec_line_engine_tb_top.sv
module spec_line_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS  = 4;
  localparam int VID_W = 8;
  localparam int WAY_W = 2;

  localparam logic [3:0] S_I = 0, S_S = 1, S_E = 2, S_O = 3, S_M = 4,
                         S_SS = 9, S_SE = 10, S_SO = 11, S_SM = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_write = 0;
  logic [WAY_W-1:0] req_way = 0;
  logic [VID_W-1:0] req_vid = 0;
  logic fill_valid = 0;
  logic [WAY_W-1:0] fill_way = 0;
  logic [3:0] fill_state = 0;
  logic [VID_W-1:0] fill_m = 0, fill_h = 0;
  logic cmd_commit = 0, cmd_abort = 0, cmd_vid_rst = 0;
  logic snp_valid = 0;
  logic [WAY_W-1:0] snp_way = 0;
  logic prb_req = 0;
  logic [WAY_W-1:0] prb_way = 0;
  logic rsp_valid, rsp_stall, rsp_reject, rsp_copy_vld, evict_req;
  logic [WAY_W-1:0] rsp_copy_way;
  logic snp_rsp_vld, snp_hit, prb_vld;
  logic [3:0] snp_state, prb_state;
  logic [VID_W-1:0] snp_m, snp_h, prb_m, prb_h;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_line_engine #(.WAYS(WAYS), .VID_W(VID_W)) dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_way(req_way), .req_vid(req_vid),
    .fill_valid(fill_valid), .fill_way(fill_way), .fill_state(fill_state),
    .fill_m(fill_m), .fill_h(fill_h),
    .cmd_commit(cmd_commit), .cmd_abort(cmd_abort), .cmd_vid_rst(cmd_vid_rst),
    .snp_valid(snp_valid), .snp_way(snp_way), .prb_req(prb_req), .prb_way(prb_way),
    .rsp_valid(rsp_valid), .rsp_stall(rsp_stall), .rsp_reject(rsp_reject),
    .rsp_copy_vld(rsp_copy_vld), .rsp_copy_way(rsp_copy_way), .evict_req(evict_req),
    .snp_rsp_vld(snp_rsp_vld), .snp_hit(snp_hit), .snp_state(snp_state),
    .snp_m(snp_m), .snp_h(snp_h),
    .prb_vld(prb_vld), .prb_state(prb_state), .prb_m(prb_m), .prb_h(prb_h)
  );

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t rsp_q[$];
  exp_t prb_q[$];
  exp_t snp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic void report(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  // Monitor: compare each produced result with the oldest expectation
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rsp_valid) begin
        logic [31:0] a;
        a = {26'd0, rsp_stall, rsp_reject, evict_req, rsp_copy_vld, rsp_copy_way};
        if (rsp_q.size() == 0) report(0, "unexpected response", a, 0);
        else begin exp_t e; e = rsp_q.pop_front(); report(a == e.v, e.tag, a, e.v); end
      end
      if (prb_vld) begin
        logic [31:0] a;
        a = {12'd0, prb_state, prb_m, prb_h};
        if (prb_q.size() == 0) report(0, "unexpected probe", a, 0);
        else begin exp_t e; e = prb_q.pop_front(); report(a == e.v, e.tag, a, e.v); end
      end
      if (snp_rsp_vld) begin
        logic [31:0] a;
        a = snp_hit ? {11'd0, 1'b1, snp_state, snp_m, snp_h} : 32'd0;
        if (snp_q.size() == 0) report(0, "unexpected snoop", a, 0);
        else begin exp_t e; e = snp_q.pop_front(); report(a == e.v, e.tag, a, e.v); end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    req_valid = 0; fill_valid = 0; cmd_commit = 0; cmd_abort = 0; cmd_vid_rst = 0;
    snp_valid = 0; prb_req = 0;
  endtask

  task automatic fill(int w, logic [3:0] s, int m, int h);
    fill_valid = 1; fill_way = WAY_W'(w); fill_state = s;
    fill_m = VID_W'(m); fill_h = VID_W'(h);
    tick();
  endtask

  task automatic set_req(int w, int vid, bit wr, bit stall, bit rej, bit ev, bit cv,
                         int cw, string tag);
    exp_t e;
    e.v = {26'd0, stall, rej, ev, cv, 2'(cw)};
    e.tag = tag;
    rsp_q.push_back(e);
    req_valid = 1; req_way = WAY_W'(w); req_vid = VID_W'(vid); req_write = wr;
  endtask

  task automatic req(int w, int vid, bit wr, bit stall, bit rej, bit ev, bit cv,
                     int cw, string tag);
    set_req(w, vid, wr, stall, rej, ev, cv, cw, tag);
    tick();
  endtask

  task automatic probe(int w, logic [3:0] s, int m, int h, string tag);
    exp_t e;
    e.v = {12'd0, s, 8'(m), 8'(h)};
    e.tag = tag;
    prb_q.push_back(e);
    prb_req = 1; prb_way = WAY_W'(w);
    tick();
  endtask

  task automatic snoop(int w, bit hit, int m, int h, string tag);
    exp_t e;
    e.v = hit ? {11'd0, 1'b1, S_SS, 8'(m), 8'(h)} : 32'd0;
    e.tag = tag;
    snp_q.push_back(e);
    snp_valid = 1; snp_way = WAY_W'(w);
    tick();
  endtask

  task automatic finish_run();
    done = 1;
    if (rsp_q.size() + prb_q.size() + snp_q.size() != 0)
      report(0, "results missing", 0, rsp_q.size() + prb_q.size() + snp_q.size());
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      report(0, "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: outputs quiet and all ways empty after reset
    report({rsp_valid, evict_req, snp_rsp_vld, prb_vld} == 4'b0, "R1 outputs idle",
           {rsp_valid, evict_req, snp_rsp_vld, prb_vld}, 0);
    for (int w = 0; w < WAYS; w++) probe(w, S_I, 0, 0, "R1 way empty");

    // R12: fill installs states
    fill(0, S_M, 0, 0);
    fill(1, S_E, 0, 0);
    probe(1, S_E, 0, 0, "R12 fill E");

    // R6: read moves M to SM, access stamp takes the maximum
    req(0, 5, 0, 0, 0, 0, 0, 0, "R6 read ok");
    probe(0, S_SM, 0, 5, "R6 read M->SM");
    req(0, 3, 0, 0, 0, 0, 0, 0, "R6 older read ok");
    probe(0, S_SM, 0, 5, "R6 h keeps max");

    // R2/R3: write to SM splits into SM (7,7) and SO (0,7) in lowest free way 2
    req(0, 7, 1, 0, 0, 0, 1, 2, "R3 write SM copy way");
    probe(0, S_SM, 7, 7, "R3 new SM range");
    probe(2, S_SO, 0, 7, "R2 SO copy range");

    // R7: snoop of SO and SM supplies SS with same range
    snoop(2, 1, 0, 7, "R7 snoop SO");
    snoop(0, 1, 7, 7, "R7 snoop SM");

    // R6/R7/R3: E read becomes SE, then write splits
    req(1, 4, 0, 0, 0, 0, 0, 0, "R6 read E");
    probe(1, S_SE, 0, 4, "R6 E->SE");
    snoop(1, 1, 0, 4, "R7 snoop SE");
    req(1, 9, 1, 0, 0, 0, 1, 3, "R3 write SE copy way");
    probe(1, S_SM, 9, 9, "R3 SE->SM");
    probe(3, S_SO, 0, 9, "R3 SO copy");

    // R4: set full, write stalls and asks for eviction
    req(0, 10, 1, 1, 0, 1, 0, 0, "R4 no free way");
    probe(0, S_SM, 7, 7, "R4 way unchanged");

    // R5: write to SO rejected; SO still readable
    req(2, 8, 1, 0, 1, 0, 0, 0, "R5 write SO rejected");
    probe(2, S_SO, 0, 7, "R5 SO unchanged");
    req(2, 8, 0, 0, 0, 0, 0, 0, "R6 read SO");
    probe(2, S_SO, 0, 8, "R6 SO h raised");

    // R7/R5: SS is silent and not writable
    fill(3, S_SS, 2, 6);
    snoop(3, 0, 0, 0, "R7 SS silent");
    req(3, 7, 1, 0, 1, 0, 0, 0, "R5 write SS rejected");
    probe(3, S_SS, 2, 6, "R5 SS unchanged");

    // R8: commit
    cmd_commit = 1; tick();
    probe(0, S_M, 7, 7, "R8 SM->M");
    probe(1, S_M, 9, 9, "R8 SM->M way1");
    probe(2, S_I, 0, 8, "R8 SO->I");
    probe(3, S_I, 2, 6, "R8 SS->I");

    // R9: abort, first mix
    fill(0, S_SE, 0, 3);
    fill(1, S_SM, 0, 4);
    fill(2, S_SM, 5, 8);
    fill(3, S_SO, 0, 8);
    cmd_abort = 1; tick();
    probe(0, S_E, 0, 3, "R9 SE->E");
    probe(1, S_M, 0, 4, "R9 SM m0->M");
    probe(2, S_I, 5, 8, "R9 SM m!=0->I");
    probe(3, S_M, 0, 8, "R9 SO m0->M");

    // R9: abort, second mix
    fill(0, S_SS, 1, 2);
    fill(1, S_SO, 3, 6);
    fill(2, S_E, 0, 0);
    fill(3, S_I, 0, 0);
    cmd_abort = 1; tick();
    probe(0, S_I, 1, 2, "R9 SS->I");
    probe(1, S_I, 3, 6, "R9 SO m!=0->I");
    probe(2, S_E, 0, 0, "R9 E untouched");

    // R5: read of Invalid way rejected
    req(3, 1, 0, 0, 1, 0, 0, 0, "R5 read I rejected");
    probe(3, S_I, 0, 0, "R5 I unchanged");

    // R10/R11: stamp reset wins over commit in the same cycle
    fill(0, S_SM, 4, 9);
    fill(1, S_O, 2, 3);
    cmd_vid_rst = 1; cmd_commit = 1; tick();
    probe(0, S_SM, 0, 0, "R10 stamps cleared state kept");
    probe(1, S_O, 0, 0, "R10 O stamps cleared");

    // R11: commit beats a write in the same cycle
    cmd_commit = 1;
    set_req(0, 12, 1, 1, 0, 0, 0, 0, "R11 write stalled by commit");
    tick();
    probe(0, S_M, 0, 0, "R11 commit applied not write");

    // R11: fill beats a read in the same cycle
    fill_valid = 1; fill_way = 1; fill_state = S_E; fill_m = 0; fill_h = 0;
    set_req(1, 5, 0, 1, 0, 0, 0, 0, "R11 read stalled by fill");
    tick();
    probe(1, S_E, 0, 0, "R11 fill applied not read");

    // R2: write to M, copy to lowest free way 3
    req(0, 3, 1, 0, 0, 0, 1, 3, "R2 write M copy way");
    probe(0, S_SM, 3, 3, "R2 M->SM");
    probe(3, S_SO, 0, 3, "R2 SO from M");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule